// File: doc/BRIEF.md
# Sector Bit-Error Patcher

This block repairs up to eight single-bit faults in one 512-byte sector after a hardware BCH decoder has finished its work. After a sector's 512 data bytes and then its 13 code bytes have been streamed through the decoder, in that order, the decoder leaves a status word and three 32-bit result words. These words hold a readiness flag, an error count and eight packed 13-bit error positions. The block does not compute syndromes or locators, and it does not drive the flash interface.

After a `start` pulse, the block waits until the status word reports that the result is ready. It then captures the words and steps through the reported positions in order. Each position has its two low bits inverted. A position that lands inside the sector is fixed by a read-modify-write on a byte RAM holding the sector. A position that lands outside the sector is skipped.

When the walk ends, the block pulses `done` with the number of bits it flipped. A count above eight is not corrected. Instead, `too_many` is raised so that a separate erased-page checker can decide whether the sector is blank or lost.

The controller is a five-state machine:
- **IDLE** goes to WAIT_RDY on `start`.
- **WAIT_RDY** stays while the ready flag is low. Once the flag is high, it goes to FINISH if the count is zero or above eight, otherwise to LOOKUP.
- **LOOKUP** goes to FINISH when every reported position has been visited. It stays in LOOKUP, moving to the next position, when the current position is out of range. It goes to PATCH when the current position is in range, issuing the RAM read.
- **PATCH** writes the toggled byte and returns to LOOKUP.
- **FINISH** pulses `done` and returns to IDLE.

Top module: `bch_err_fixer`

## Requirements
- R1: After reset, `busy`, `done`, `too_many`, `mem_re` and `mem_we` are 0, and `fix_count` is 0.
- R2: `start` in IDLE begins a run. While `status_word[15]` is 0, the block waits: it makes no RAM access and raises no `done`.
- R3: The 13-bit position k comes from the concatenation {`status_word[23:16]`, `res_w3`, `res_w2`, `res_w1`}, bits 13k+12 down to 13k. So position 2 is {`res_w2[6:0]`, `res_w1[31:26]`}, position 4 is {`res_w3[0]`, `res_w2[31:20]`}, and position 7 is {`status_word[23:16]`, `res_w3[31:27]`}.
- R4: Each position is XORed with 3 before use. An adjusted value p below 4096 toggles bit p[2:0] of RAM byte p>>3, and every other RAM byte is left as it was.
- R5: An adjusted value of 4096 or more is skipped. It makes no RAM access and is not counted.
- R6: The count is `status_word[13:10]`. Only positions 0 to count−1 are processed, in ascending order, so a repeated position toggles its bit twice. `fix_count` at `done` equals the number of positions applied.
- R7: A count of 0 ends the run with `fix_count` 0, `too_many` 0 and no RAM access.
- R8: A count from 9 to 15 ends the run with `too_many` 1, `fix_count` 0 and no RAM access.
- R9: The RAM read data arrives one cycle after `mem_re`. Each applied position asserts `mem_re` for one cycle, then `mem_we` in the next cycle at the same address, with `mem_wdata` equal to `mem_rdata` with the target bit inverted.
- R10: `done` is a one-cycle pulse. Let d be the number of edges spent waiting for the ready flag. For counts 1 to 8 with a positions applied and s skipped, `done` rises d+2+2a+s edges after the edge that samples `start`. For a count of 0 or above 8, it rises d+1 edges after that edge.
- R11: `start` has no effect while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a correction run (honoured only when idle) |
| status_word | input | 32 | Bit 15 ready, bits 13:10 error count, bits 23:16 high part of position 7 |
| res_w1 | input | 32 | First result word |
| res_w2 | input | 32 | Second result word |
| res_w3 | input | 32 | Third result word |
| mem_addr | output | 9 | Sector RAM byte address |
| mem_re | output | 1 | Sector RAM read strobe |
| mem_rdata | input | 8 | Sector RAM read data, one cycle after `mem_re` |
| mem_we | output | 1 | Sector RAM write strobe |
| mem_wdata | output | 8 | Sector RAM write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fix_count | output | 4 | Number of bits corrected |
| too_many | output | 1 | Count above eight; no correction made |

## Verification
Several internal faults show up at the ports in the run they occur in:
- A wrong unpacking slice or a missing XOR adjust toggles the wrong RAM byte or bit. The full-sector compare sees this at the `done` of that run.
- A broken position index or range test changes the number of RAM accesses and shifts `done` by one or two cycles. The access counter and the latency check report this at that same `done`.
- A corrupted count or overflow flag shows directly on `fix_count` or `too_many` at `done`.
- A state that leaks past FINISH keeps `busy` high or stretches `done` into the next cycle.

// File: rtl/bch_fix_pkg.sv
package bch_fix_pkg;

    // Sector geometry and report layout
    localparam int SECTOR_BYTES = 512;
    localparam int NUM_POS      = 8;
    localparam int POS_W        = 13;
    localparam int ADDR_W       = $clog2(SECTOR_BYTES);
    localparam int BIT_LIMIT    = SECTOR_BYTES * 8;
    localparam int CNT_W        = 4;
    localparam int IDX_W        = $clog2(NUM_POS);
    localparam int READY_BIT    = 15;
    localparam int CNT_LSB      = 10;
    localparam int HI_LSB       = 16;
    localparam int HI_W         = NUM_POS * POS_W - 96;
    localparam logic [POS_W-1:0] ADJ_MASK = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_RDY,
        ST_LOOKUP,
        ST_PATCH,
        ST_FINISH
    } fix_state_e;

    typedef logic [NUM_POS-1:0][POS_W-1:0] pos_vec_t;

endpackage

// File: rtl/bch_pos_unpack.sv
module bch_pos_unpack
    import bch_fix_pkg::*;
(
    input  logic [31:0]   w1,
    input  logic [31:0]   w2,
    input  logic [31:0]   w3,
    input  logic [HI_W-1:0] hi,
    output pos_vec_t      pos_adj
);

    pos_vec_t pos_raw;

    // Field extraction; positions 2, 4 and 7 straddle word boundaries
    always_comb begin
        pos_raw[0] = w1[12:0];
        pos_raw[1] = w1[25:13];
        pos_raw[2] = {w2[6:0], w1[31:26]};
        pos_raw[3] = w2[19:7];
        pos_raw[4] = {w3[0], w2[31:20]};
        pos_raw[5] = w3[13:1];
        pos_raw[6] = w3[26:14];
        pos_raw[7] = {hi, w3[31:27]};
    end

    genvar g;
    generate
        for (g = 0; g < NUM_POS; g++) begin : g_adj
            assign pos_adj[g] = pos_raw[g] ^ ADJ_MASK;
        end
    endgenerate

endmodule

// File: rtl/bch_pos_locate.sv
module bch_pos_locate
    import bch_fix_pkg::*;
(
    input  logic [POS_W-1:0]  pos,
    output logic              in_range,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [2:0]        bit_sel
);

    assign in_range  = (pos < POS_W'(BIT_LIMIT));
    assign byte_addr = pos[ADDR_W+2:3];
    assign bit_sel   = pos[2:0];

    logic unused_pos_hi;
    assign unused_pos_hi = ^pos[POS_W-1:ADDR_W+3];

endmodule

// File: rtl/bch_err_fixer.sv
module bch_err_fixer
    import bch_fix_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       status_word,
    input  logic [31:0]       res_w1,
    input  logic [31:0]       res_w2,
    input  logic [31:0]       res_w3,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    input  logic [7:0]        mem_rdata,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  fix_count,
    output logic              too_many
);

    fix_state_e state_q, state_d;

    logic [31:0]       w1_q, w2_q, w3_q;
    logic [HI_W-1:0]   hi_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  idx_q;
    logic [CNT_W-1:0]  fixed_q;
    logic              over_q;
    logic [ADDR_W-1:0] byte_q;
    logic [2:0]        bit_q;

    pos_vec_t          pos_adj;
    logic              cur_in_range;
    logic [ADDR_W-1:0] cur_byte;
    logic [2:0]        cur_bit;

    logic              ready;
    logic [CNT_W-1:0]  live_cnt;
    logic              live_over;
    logic              live_zero;
    logic              walk_end;

    assign ready     = status_word[READY_BIT];
    assign live_cnt  = status_word[CNT_LSB+CNT_W-1:CNT_LSB];
    assign live_over = (live_cnt > CNT_W'(NUM_POS));
    assign live_zero = (live_cnt == '0);
    assign walk_end  = (idx_q == cnt_q);

    logic unused_status_bits;
    assign unused_status_bits = ^{status_word[31:HI_LSB+HI_W], status_word[READY_BIT-1:CNT_LSB+CNT_W],
                                  status_word[CNT_LSB-1:0]};

    bch_pos_unpack u_unpack (
        .w1      (w1_q),
        .w2      (w2_q),
        .w3      (w3_q),
        .hi      (hi_q),
        .pos_adj (pos_adj)
    );

    bch_pos_locate u_locate (
        .pos       (pos_adj[idx_q[IDX_W-1:0]]),
        .in_range  (cur_in_range),
        .byte_addr (cur_byte),
        .bit_sel   (cur_bit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_WAIT_RDY;
            ST_WAIT_RDY: begin
                if (ready) begin
                    if (live_zero || live_over) state_d = ST_FINISH;
                    else                        state_d = ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                if (walk_end)          state_d = ST_FINISH;
                else if (cur_in_range) state_d = ST_PATCH;
                else                   state_d = ST_LOOKUP;
            end
            ST_PATCH:    state_d = ST_LOOKUP;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w1_q    <= '0;
            w2_q    <= '0;
            w3_q    <= '0;
            hi_q    <= '0;
            cnt_q   <= '0;
            idx_q   <= '0;
            fixed_q <= '0;
            over_q  <= 1'b0;
            byte_q  <= '0;
            bit_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        fixed_q <= '0;
                        over_q  <= 1'b0;
                        idx_q   <= '0;
                    end
                end
                ST_WAIT_RDY: begin
                    if (ready) begin
                        w1_q   <= res_w1;
                        w2_q   <= res_w2;
                        w3_q   <= res_w3;
                        hi_q   <= status_word[HI_LSB+HI_W-1:HI_LSB];
                        cnt_q  <= live_cnt;
                        over_q <= live_over;
                    end
                end
                ST_LOOKUP: begin
                    if (!walk_end) begin
                        if (cur_in_range) begin
                            byte_q <= cur_byte;
                            bit_q  <= cur_bit;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_PATCH: begin
                    fixed_q <= fixed_q + 1'b1;
                    idx_q   <= idx_q + 1'b1;
                end
                ST_FINISH: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_byte;
        mem_wdata = mem_rdata;
        unique case (state_q)
            ST_LOOKUP: begin
                mem_re = !walk_end && cur_in_range;
            end
            ST_PATCH: begin
                mem_addr  = byte_q;
                mem_we    = 1'b1;
                mem_wdata = mem_rdata ^ (8'd1 << bit_q);
            end
            default: ;
        endcase
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = (state_q == ST_FINISH);
    assign fix_count = fixed_q;
    assign too_many  = over_q;

    // R9
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (mem_we && mem_addr == $past(mem_addr)));

    // R9
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(mem_re));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R8
    overflow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && too_many) |-> (fix_count == '0));

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fix_count <= CNT_W'(NUM_POS));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_re && !mem_we));

endmodule

// File: tb/tb_bch_err_fixer.sv
module tb_bch_err_fixer;

    localparam int NBYTES = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] status_word = '0;
    logic [31:0] res_w1 = '0, res_w2 = '0, res_w3 = '0;
    logic [8:0]  mem_addr;
    logic        mem_re, mem_we;
    logic [7:0]  mem_rdata = '0;
    logic [7:0]  mem_wdata;
    logic        busy, done, too_many;
    logic [3:0]  fix_count;

    logic [7:0]  ram  [NBYTES];
    logic [7:0]  gold [NBYTES];
    int          acc_cnt = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;

    always #5 clk = ~clk;

    bch_err_fixer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .status_word(status_word),
        .res_w1(res_w1), .res_w2(res_w2), .res_w3(res_w3),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .busy(busy), .done(done),
        .fix_count(fix_count), .too_many(too_many)
    );

    // Sector RAM model, one-cycle read latency
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_we) begin
            ram[mem_addr] <= mem_wdata;
            acc_cnt <= acc_cnt + 1;
        end
        if (mem_re) begin
            mem_rdata <= ram[mem_addr];
            acc_cnt <= acc_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < NBYTES; i++) begin
            ram[i]  = 8'((i * 37 + seed) & 255);
            gold[i] = ram[i];
        end
    endtask

    // raw: slot k in bits 13k+12..13k; delay: edges the ready flag stays low
    task automatic run_case(input logic [7:0][12:0] raw, input logic [3:0] cnt,
                            input int delay, input bit poke_start);
        int a = 0, s = 0, exp_lat, lat, acc0, mism;
        logic [103:0] v;
        logic [12:0]  adj;
        if (cnt >= 1 && cnt <= 8) begin
            for (int k = 0; k < int'(cnt); k++) begin
                adj = raw[k] ^ 13'd3;
                if (adj < 13'd4096) begin
                    gold[adj >> 3] = gold[adj >> 3] ^ (8'd1 << adj[2:0]);
                    a++;
                end else s++;
            end
            exp_lat = delay + 2 + 2 * a + s;
        end else exp_lat = delay + 1;
        v = raw;
        @(negedge clk);
        res_w1 = v[31:0];
        res_w2 = v[63:32];
        res_w3 = v[95:64];
        status_word = '0;
        status_word[23:16] = v[103:96];
        status_word[13:10] = cnt;
        status_word[15] = (delay == 0);
        acc0 = acc_cnt;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        for (int t = 0; t < 64; t++) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (lat == delay) status_word[15] = 1'b1;
            if (poke_start && lat == 2) start = 1'b1;   // R11
            if (poke_start && lat == 3) start = 1'b0;
            if (done) break;
        end
        start = 1'b0;
        // R2 R10: latency including ready wait
        check(done && lat == exp_lat, "R10 latency", lat, exp_lat);
        // R6 R7 R5
        check(fix_count == 4'(a), "R6 fix_count", fix_count, a);
        // R8
        check(too_many == (cnt > 8), "R8 too_many", too_many, cnt > 8);
        // R9 R5 R7: two accesses per applied position only
        check(acc_cnt - acc0 == 2 * a, "R9 access count", acc_cnt - acc0, 2 * a);
        @(posedge clk);
        @(negedge clk);
        // R10: single-cycle done
        check(!done && !busy, "R10 done pulse", done, 0);
        mism = 0;
        for (int i = 0; i < NBYTES; i++) if (ram[i] !== gold[i]) mism++;
        // R3 R4: sector contents
        check(mism == 0, "R4 sector bytes", mism, 0);
    endtask

    initial begin
        #1900000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0][12:0] raw;
        fill(5);
        repeat (3) @(negedge clk);
        // R1
        check(!busy && !done && !too_many && fix_count == 0 && !mem_re && !mem_we,
              "R1 reset outputs", {busy, done, too_many, mem_re, mem_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4: sweep every raw value through slot r%8, earlier slots out of range
        for (int r = 0; r < 4096; r++) begin
            for (int k = 0; k < 8; k++) raw[k] = 13'h1000 | 13'((r * 7 + k) & 13'hFFF);
            raw[r % 8] = 13'(r);
            run_case(raw, 4'((r % 8) + 1), 0, 1'b0);
        end

        // R5: adjusted 4096 exactly is skipped
        raw = '0;
        raw[0] = 13'h1003;
        raw[1] = 13'hFFC;
        run_case(raw, 4'd2, 0, 1'b0);

        // R6: only the first three of eight in-range slots applied
        for (int k = 0; k < 8; k++) raw[k] = 13'(k * 300 + 11);
        run_case(raw, 4'd3, 0, 1'b0);

        // R6: all eight, with a repeated position and a shared byte
        raw[0] = 13'd100; raw[1] = 13'd100; raw[2] = 13'd101; raw[3] = 13'd4000;
        raw[4] = 13'd7;   raw[5] = 13'd2048; raw[6] = 13'd4095; raw[7] = 13'd555;
        run_case(raw, 4'd8, 0, 1'b0);

        // R7: zero count, positions ignored
        run_case(raw, 4'd0, 0, 1'b0);

        // R8: every overflow count
        for (int c = 9; c < 16; c++) run_case(raw, 4'(c), 0, 1'b0);

        // R2: ready held low for several cycles
        run_case(raw, 4'd4, 5, 1'b0);
        run_case(raw, 4'd0, 3, 1'b0);

        // R11: start pulsed mid-run is ignored
        run_case(raw, 4'd8, 0, 1'b1);
        run_case(raw, 4'd5, 4, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule